// File: doc/BRIEF.md
# Keyboard Controller Command Engine

This block is the host-facing command engine of a legacy keyboard and pointing-device controller. The host reaches it through two byte-wide ports that share one write bus. A write on the command port carries a single-byte controller command. A write on the data port carries either the operand of a command that is waiting for it, or a byte for the keyboard device. A read strobe on the command port returns the status register.

The engine keeps three pieces of state: the mode register, the status register and a latch that holds the command still waiting for its operand. Reply bytes leave as one-cycle pushes toward an output queue, tagged with a keyboard or auxiliary channel bit. Bytes meant for the attached devices, writes to the output port, requests to re-evaluate the interrupts and system-reset requests leave as one-cycle pulses as well. All of these outputs are registered, so each pulse appears in the cycle after the strobe that caused it.

The queues, the serial device protocols, the interrupt logic and the output-port pins sit outside the block. The engine meets them only through these pulses and the current output-port value, which it receives as an input.

Top module: `kbc_cmd_engine`

## Requirements
- R1: After a synchronous reset, mode reads 0x03 (both interrupt enables), status reads 0x18 (bits 3 and 4), the translation enable is low and no pulse output is active.
- R2: Command 0x20 pushes the current mode byte on the keyboard channel (channel bit q_aux = 0).
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 produce no output and no register change of their own. They are held as the pending command until the next data-port write, which that command consumes. The pending command then clears.
- R4: A data-port write while no command is pending gives a keyboard-device push (dev_push with dev_aux = 0) that carries the byte.
- R5: The byte that follows 0x60 replaces the mode register and pulses irq_eval. xlat_en then follows mode bit 6.
- R6: The byte that follows 0xD2 is pushed on the keyboard channel, the byte that follows 0xD3 on the aux channel (q_aux = 1), and the byte that follows 0xD4 goes to the aux device (dev_push with dev_aux = 1).
- R7: The byte that follows 0xD1 is sent as an output-port write (op_wr, op_byte). Command 0xD0 pushes the op_val input on the keyboard channel.
- R8: Command 0xAA sets status bit 2 and pushes 0x55. Commands 0xA9 and 0xAB push 0x00, and 0xC0 pushes 0x80. Status bit 2 is the only status bit that ever changes.
- R9: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4, and each also pulses irq_eval.
- R10: A command byte whose upper nibble is 0xF acts as a reset request (sys_reset_req pulse) when bit 0 is 0, and as a no-op when bit 0 is 1.
- R11: Unknown command bytes change no register and raise no pulse. A status read returns the status register and changes nothing.
- R12: A pending command waits with no time limit. Other commands that arrive meanwhile do not disturb it, and a later write-type command replaces it.
- R13: When the command and data strobes fire in the same cycle, the command is carried out and the data write is dropped.
- R14: Each output pulse is high for exactly the one cycle after the strobe edge that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command-port write strobe |
| data_wr | input | 1 | Data-port write strobe |
| stat_rd | input | 1 | Command-port (status) read strobe |
| wr_data | input | 8 | Shared write byte |
| op_val | input | 8 | Current output-port value |
| rd_data | output | 8 | Status byte captured on stat_rd |
| mode_q | output | 8 | Mode register |
| xlat_en | output | 1 | Scan-code translation enable (mode bit 6) |
| q_push | output | 1 | Reply-queue push pulse |
| q_aux | output | 1 | Reply channel: 0 keyboard, 1 aux |
| q_byte | output | 8 | Reply byte |
| dev_push | output | 1 | Device-write pulse |
| dev_aux | output | 1 | Device select: 0 keyboard, 1 aux |
| dev_byte | output | 8 | Device byte |
| op_wr | output | 1 | Output-port write pulse |
| op_byte | output | 8 | Output-port byte |
| irq_eval | output | 1 | Interrupt re-evaluation pulse |
| sys_reset_req | output | 1 | System reset request pulse |

## Verification
The bench targets the nibble fold. 0xF0 and 0xFE must both raise a reset request, while 0xF7 and 0xFF must raise nothing; a design that compared the full byte would miss 0xF0 or pulse on 0xF7. It also checks that the pending command survives an idle gap and an unrelated command, and that a second write-type command replaces it. A design that cleared the latch on any command would send the operand to the keyboard instead. In the same-cycle collision case the shared byte would also be a legal operand, so a design that let the data write through would show a spurious push. The test also confirms that an unknown command leaves nothing pending, so the next data byte must still reach the keyboard device.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t OP_RD_MODE   = 8'h20;
  localparam byte_t OP_WR_MODE   = 8'h60;
  localparam byte_t OP_AUX_OFF   = 8'hA7;
  localparam byte_t OP_AUX_ON    = 8'hA8;
  localparam byte_t OP_AUX_TEST  = 8'hA9;
  localparam byte_t OP_SELFTEST  = 8'hAA;
  localparam byte_t OP_KBD_TEST  = 8'hAB;
  localparam byte_t OP_KBD_OFF   = 8'hAD;
  localparam byte_t OP_KBD_ON    = 8'hAE;
  localparam byte_t OP_RD_INPORT = 8'hC0;
  localparam byte_t OP_RD_OUT    = 8'hD0;
  localparam byte_t OP_WR_OUT    = 8'hD1;
  localparam byte_t OP_WR_KQ     = 8'hD2;
  localparam byte_t OP_WR_AQ     = 8'hD3;
  localparam byte_t OP_WR_AUXDEV = 8'hD4;
  localparam byte_t OP_RESET     = 8'hFE;
  localparam byte_t OP_NOP       = 8'hFF;

  localparam byte_t RPL_PASS  = 8'h55;
  localparam byte_t RPL_OK    = 8'h00;
  localparam byte_t RPL_INPRT = 8'h80;

  localparam int M_XLAT    = 6;
  localparam int M_AUX_DIS = 5;
  localparam int M_KBD_DIS = 4;
  localparam int S_PASS    = 2;

  typedef struct packed {
    logic  pend_we;
    byte_t pend_nv;
    logic  mode_we;
    byte_t mode_nv;
    logic  st_pass;
    logic  irq_ev;
    logic  sys_rst;
    logic  q_push;
    logic  q_aux;
    byte_t q_byte;
    logic  dev_push;
    logic  dev_aux;
    byte_t dev_byte;
    logic  op_wr;
    byte_t op_byte;
  } act_t;

  function automatic logic takes_operand(byte_t c);
    return (c == OP_WR_MODE) || (c == OP_WR_OUT) || (c == OP_WR_KQ) ||
           (c == OP_WR_AQ) || (c == OP_WR_AUXDEV);
  endfunction
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  byte_t cmd,
  input  byte_t mode,
  input  byte_t op_val,
  output act_t  act
);
  byte_t c;

  always_comb begin
    // bytes 0xF0..0xFF collapse onto reset or no-op by bit 0
    if (cmd[BYTE_W-1:BYTE_W-4] == 4'hF) c = cmd[0] ? OP_NOP : OP_RESET;
    else                                c = cmd;

    act = '0;
    case (c)
      OP_RD_MODE: begin
        act.q_push = 1'b1;
        act.q_byte = mode;
      end
      OP_WR_MODE, OP_WR_OUT, OP_WR_KQ, OP_WR_AQ, OP_WR_AUXDEV: begin
        act.pend_we = 1'b1;
        act.pend_nv = c;
      end
      OP_AUX_OFF: begin
        act.mode_we = 1'b1;
        act.mode_nv = mode;
        act.mode_nv[M_AUX_DIS] = 1'b1;
      end
      OP_AUX_ON: begin
        act.mode_we = 1'b1;
        act.mode_nv = mode;
        act.mode_nv[M_AUX_DIS] = 1'b0;
      end
      OP_AUX_TEST, OP_KBD_TEST: begin
        act.q_push = 1'b1;
        act.q_byte = RPL_OK;
      end
      OP_SELFTEST: begin
        act.st_pass = 1'b1;
        act.q_push  = 1'b1;
        act.q_byte  = RPL_PASS;
      end
      OP_KBD_OFF: begin
        act.mode_we = 1'b1;
        act.mode_nv = mode;
        act.mode_nv[M_KBD_DIS] = 1'b1;
        act.irq_ev  = 1'b1;
      end
      OP_KBD_ON: begin
        act.mode_we = 1'b1;
        act.mode_nv = mode;
        act.mode_nv[M_KBD_DIS] = 1'b0;
        act.irq_ev  = 1'b1;
      end
      OP_RD_INPORT: begin
        act.q_push = 1'b1;
        act.q_byte = RPL_INPRT;
      end
      OP_RD_OUT: begin
        act.q_push = 1'b1;
        act.q_byte = op_val;
      end
      OP_RESET: act.sys_rst = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/kbc_data_route.sv
module kbc_data_route
  import kbc_pkg::*;
(
  input  byte_t pend,
  input  byte_t din,
  output act_t  act
);
  always_comb begin
    act = '0;
    act.pend_we = 1'b1;
    act.pend_nv = '0;
    case (pend)
      OP_WR_MODE: begin
        act.mode_we = 1'b1;
        act.mode_nv = din;
        act.irq_ev  = 1'b1;
      end
      OP_WR_OUT: begin
        act.op_wr   = 1'b1;
        act.op_byte = din;
      end
      OP_WR_KQ: begin
        act.q_push = 1'b1;
        act.q_byte = din;
      end
      OP_WR_AQ: begin
        act.q_push = 1'b1;
        act.q_aux  = 1'b1;
        act.q_byte = din;
      end
      OP_WR_AUXDEV: begin
        act.dev_push = 1'b1;
        act.dev_aux  = 1'b1;
        act.dev_byte = din;
      end
      default: begin
        act.dev_push = 1'b1;
        act.dev_byte = din;
      end
    endcase
  end
endmodule

// File: rtl/kbc_out_stage.sv
module kbc_out_stage
  import kbc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  act_t  act,
  output logic  q_push,
  output logic  q_aux,
  output byte_t q_byte,
  output logic  dev_push,
  output logic  dev_aux,
  output byte_t dev_byte,
  output logic  op_wr,
  output byte_t op_byte,
  output logic  irq_eval,
  output logic  sys_reset_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_push        <= 1'b0;
      q_aux         <= 1'b0;
      q_byte        <= '0;
      dev_push      <= 1'b0;
      dev_aux       <= 1'b0;
      dev_byte      <= '0;
      op_wr         <= 1'b0;
      op_byte       <= '0;
      irq_eval      <= 1'b0;
      sys_reset_req <= 1'b0;
    end else begin
      q_push        <= act.q_push;
      q_aux         <= act.q_aux;
      q_byte        <= act.q_byte;
      dev_push      <= act.dev_push;
      dev_aux       <= act.dev_aux;
      dev_byte      <= act.dev_byte;
      op_wr         <= act.op_wr;
      op_byte       <= act.op_byte;
      irq_eval      <= act.irq_ev;
      sys_reset_req <= act.sys_rst;
    end
  end
endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
  import kbc_pkg::*;
#(
  parameter logic [7:0] MODE_RST = 8'h03,
  parameter logic [7:0] STAT_RST = 8'h18
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_wr,
  input  logic       data_wr,
  input  logic       stat_rd,
  input  logic [7:0] wr_data,
  input  logic [7:0] op_val,
  output logic [7:0] rd_data,
  output logic [7:0] mode_q,
  output logic       xlat_en,
  output logic       q_push,
  output logic       q_aux,
  output logic [7:0] q_byte,
  output logic       dev_push,
  output logic       dev_aux,
  output logic [7:0] dev_byte,
  output logic       op_wr,
  output logic [7:0] op_byte,
  output logic       irq_eval,
  output logic       sys_reset_req
);
  byte_t mode_r, stat_r, pend_r;
  act_t  act_c, act_d, act_s;

  kbc_cmd_decode u_dec (
    .cmd(wr_data), .mode(mode_r), .op_val(op_val), .act(act_c)
  );

  kbc_data_route u_route (
    .pend(pend_r), .din(wr_data), .act(act_d)
  );

  // command port wins a same-cycle collision; the data write is dropped
  always_comb begin
    if (cmd_wr)       act_s = act_c;
    else if (data_wr) act_s = act_d;
    else              act_s = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r  <= MODE_RST;
      stat_r  <= STAT_RST;
      pend_r  <= '0;
      rd_data <= '0;
    end else begin
      if (act_s.mode_we) mode_r <= act_s.mode_nv;
      if (act_s.pend_we) pend_r <= act_s.pend_nv;
      if (act_s.st_pass) stat_r[S_PASS] <= 1'b1;
      if (stat_rd)       rd_data <= stat_r;
    end
  end

  assign mode_q  = mode_r;
  assign xlat_en = mode_r[M_XLAT];

  kbc_out_stage u_out (
    .clk(clk), .rst(rst), .act(act_s),
    .q_push(q_push), .q_aux(q_aux), .q_byte(q_byte),
    .dev_push(dev_push), .dev_aux(dev_aux), .dev_byte(dev_byte),
    .op_wr(op_wr), .op_byte(op_byte),
    .irq_eval(irq_eval), .sys_reset_req(sys_reset_req)
  );

  // R3
  pend_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_r == 8'h00) || takes_operand(pend_r));

  // R3
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !cmd_wr) |=> (pend_r == 8'h00));

  // R13
  collide_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && data_wr) |=> (!dev_push && !op_wr));

  // R8
  stat_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    $stable({stat_r[7:3], stat_r[1:0]}));

  // R5
  xlat_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(xlat_en) |-> $past(data_wr && !cmd_wr));

  // R14
  push_src_chk: assert property (@(posedge clk) disable iff (rst)
    (q_push || dev_push || op_wr) |-> $past(cmd_wr || data_wr));

  // R11
  rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !cmd_wr && !data_wr) |=> ($stable(mode_r) && $stable(pend_r)));

  // R10
  rst_req_chk: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |-> $past(cmd_wr && (wr_data[7:4] == 4'hF) && !wr_data[0]));
endmodule

// File: tb/sim_kbc_cmd_engine.sv
module sim_kbc_cmd_engine;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst, cmd_wr, data_wr, stat_rd;
  logic [7:0] wr_data, op_val;
  logic [7:0] rd_data, mode_q, q_byte, dev_byte, op_byte;
  logic       xlat_en, q_push, q_aux, dev_push, dev_aux, op_wr, irq_eval, sys_reset_req;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  kbc_cmd_engine u0 (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .data_wr(data_wr), .stat_rd(stat_rd),
    .wr_data(wr_data), .op_val(op_val), .rd_data(rd_data), .mode_q(mode_q),
    .xlat_en(xlat_en), .q_push(q_push), .q_aux(q_aux), .q_byte(q_byte),
    .dev_push(dev_push), .dev_aux(dev_aux), .dev_byte(dev_byte),
    .op_wr(op_wr), .op_byte(op_byte), .irq_eval(irq_eval), .sys_reset_req(sys_reset_req)
  );

  task automatic ck(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pulses();
    return {3'b000, q_push, dev_push, op_wr, irq_eval, sys_reset_req};
  endfunction

  task automatic issue(input logic c, input logic d, input logic [7:0] b);
    @(negedge clk);
    cmd_wr = c; data_wr = d; wr_data = b;
    @(posedge clk); #1;
    cmd_wr = 1'b0; data_wr = 1'b0;
  endtask

  task automatic rd_status(output logic [7:0] s);
    @(negedge clk);
    stat_rd = 1'b1;
    @(posedge clk); #1;
    stat_rd = 1'b0;
    s = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] s;
    ck("R1 mode", mode_q, 8'h03);
    ck("R1 xlat", {7'd0, xlat_en}, 8'h00);
    ck("R1 pulses", pulses(), 8'h00);
    rd_status(s);
    ck("R1 status", s, 8'h18);
  endtask

  task automatic t_read_mode();
    issue(1, 0, 8'h20);
    ck("R2 push", {7'd0, q_push}, 8'h01);
    ck("R2 chan", {7'd0, q_aux}, 8'h00);
    ck("R2 byte", q_byte, 8'h03);
    @(posedge clk); #1;
    ck("R14 one cycle", pulses(), 8'h00);
  endtask

  task automatic t_replies();
    issue(1, 0, 8'hA9); ck("R8 A9", {q_push, q_aux, 6'd0}, 8'h80); ck("R8 A9 byte", q_byte, 8'h00);
    issue(1, 0, 8'hAB); ck("R8 AB", q_byte, 8'h00);
    issue(1, 0, 8'hC0); ck("R8 C0", q_byte, 8'h80);
    issue(1, 0, 8'hD0); ck("R7 D0", {q_push, q_aux, 6'd0}, 8'h80); ck("R7 D0 byte", q_byte, 8'hCF);
  endtask

  task automatic t_selftest();
    logic [7:0] s;
    issue(1, 0, 8'hAA);
    ck("R8 AA byte", q_byte, 8'h55);
    ck("R8 AA push", {7'd0, q_push}, 8'h01);
    rd_status(s);
    ck("R8 status", s, 8'h1C);
  endtask

  task automatic t_mode_bits();
    issue(1, 0, 8'hA7); ck("R9 A7", mode_q, 8'h23); ck("R9 A7 no ev", {7'd0, irq_eval}, 8'h00);
    issue(1, 0, 8'hA8); ck("R9 A8", mode_q, 8'h03);
    issue(1, 0, 8'hAD); ck("R9 AD", mode_q, 8'h13); ck("R9 AD ev", {7'd0, irq_eval}, 8'h01);
    issue(1, 0, 8'hAE); ck("R9 AE", mode_q, 8'h03); ck("R9 AE ev", {7'd0, irq_eval}, 8'h01);
  endtask

  task automatic t_kbd_default();
    issue(0, 1, 8'hED);
    ck("R4 dev", {dev_push, dev_aux, q_push, 5'd0}, 8'h80);
    ck("R4 byte", dev_byte, 8'hED);
  endtask

  task automatic t_write_mode();
    issue(1, 0, 8'h60);
    ck("R3 silent", pulses(), 8'h00);
    ck("R3 mode held", mode_q, 8'h03);
    issue(0, 1, 8'h43);
    ck("R5 mode", mode_q, 8'h43);
    ck("R5 xlat", {7'd0, xlat_en}, 8'h01);
    ck("R5 ev", {7'd0, irq_eval}, 8'h01);
    ck("R5 no dev", {7'd0, dev_push}, 8'h00);
    issue(0, 1, 8'h12);
    ck("R3 cleared", {dev_push, dev_aux, 6'd0}, 8'h80);
    ck("R3 cleared byte", dev_byte, 8'h12);
    issue(1, 0, 8'h60); issue(0, 1, 8'h03);
    ck("R5 xlat off", {7'd0, xlat_en}, 8'h00);
  endtask

  task automatic t_obuf();
    issue(1, 0, 8'hD2); issue(0, 1, 8'h7E);
    ck("R6 D2", {q_push, q_aux, dev_push, 5'd0}, 8'h80); ck("R6 D2 byte", q_byte, 8'h7E);
    issue(1, 0, 8'hD3); issue(0, 1, 8'h5A);
    ck("R6 D3", {q_push, q_aux, dev_push, 5'd0}, 8'hC0); ck("R6 D3 byte", q_byte, 8'h5A);
    issue(1, 0, 8'hD4); issue(0, 1, 8'hF4);
    ck("R6 D4", {dev_push, dev_aux, q_push, 5'd0}, 8'hC0); ck("R6 D4 byte", dev_byte, 8'hF4);
  endtask

  task automatic t_outport();
    issue(1, 0, 8'hD1);
    ck("R3 D1 silent", pulses(), 8'h00);
    issue(0, 1, 8'hDD);
    ck("R7 op_wr", {op_wr, q_push, dev_push, 5'd0}, 8'h80);
    ck("R7 op_byte", op_byte, 8'hDD);
  endtask

  task automatic t_fold();
    issue(1, 0, 8'hF0); ck("R10 F0", pulses(), 8'h01);
    issue(1, 0, 8'hFE); ck("R10 FE", pulses(), 8'h01);
    issue(1, 0, 8'hF7); ck("R10 F7", pulses(), 8'h00); ck("R10 F7 mode", mode_q, 8'h03);
    issue(1, 0, 8'hFF); ck("R10 FF", pulses(), 8'h00);
  endtask

  task automatic t_unknown();
    logic [7:0] s;
    issue(1, 0, 8'h55);
    ck("R11 no pulse", pulses(), 8'h00);
    ck("R11 mode", mode_q, 8'h03);
    rd_status(s); ck("R11 status", s, 8'h1C);
    rd_status(s); ck("R11 status again", s, 8'h1C);
    ck("R11 read no mode chg", mode_q, 8'h03);
    issue(0, 1, 8'h21);
    ck("R11 nothing pending", {dev_push, dev_aux, 6'd0}, 8'h80);
  endtask

  task automatic t_pending();
    issue(1, 0, 8'hD2);
    repeat (20) @(posedge clk);
    issue(1, 0, 8'h20);
    ck("R12 other cmd", q_byte, 8'h03);
    issue(0, 1, 8'h66);
    ck("R12 held", {q_push, q_aux, dev_push, 5'd0}, 8'h80); ck("R12 held byte", q_byte, 8'h66);
    issue(1, 0, 8'hD2); issue(1, 0, 8'hD3); issue(0, 1, 8'h99);
    ck("R12 replaced", {q_push, q_aux, 6'd0}, 8'hC0); ck("R12 replaced byte", q_byte, 8'h99);
  endtask

  task automatic t_both();
    issue(1, 0, 8'hD2);
    issue(1, 1, 8'hA7);
    ck("R13 cmd done", mode_q, 8'h23);
    ck("R13 data dropped", pulses(), 8'h00);
    issue(0, 1, 8'h44);
    ck("R13 still pending", {q_push, q_aux, 6'd0}, 8'h80); ck("R13 byte", q_byte, 8'h44);
    issue(1, 0, 8'hA8);
    ck("R9 restore", mode_q, 8'h03);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cmd_wr = 1'b0; data_wr = 1'b0; stat_rd = 1'b0;
    wr_data = 8'h00; op_val = 8'hCF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    t_reset();
    t_read_mode();
    t_replies();
    t_selftest();
    t_mode_bits();
    t_kbd_default();
    t_write_mode();
    t_obuf();
    t_outport();
    t_fold();
    t_unknown();
    t_pending();
    t_both();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule